// File: doc/BRIEF.md
# XOR Decompressor Pattern Encodability Checker

This block decides whether a scan test pattern can be delivered through a combinational XOR decompressor. Each scan chain is fed by the XOR of a fixed subset of the scan-in channels. In every shift cycle, which is one slice of the pattern, the channels carry a fresh set of free variables. A chain whose target bit is a care bit contributes one linear equation over GF(2). A chain marked don't-care contributes nothing.

On a start pulse the block captures the whole pattern and the channel matrix. It then walks the slices in order. For each slice it runs Gaussian elimination over GF(2), one pivot column per cycle. It reports each slice as solvable or unsolvable, together with one channel assignment that produces the slice. After the last slice it raises a done pulse with the pattern verdict: the pattern is encodable only if every slice is solvable.

Top module: `xdec_pattern_check`

## Requirements
- R1: After reset, busy, done and slice_valid are all low.
- R2: Matrix bit i*N_CHAN+j set means channel j feeds chain i. Pattern bit s*N_CHAINS+i holds chain i in slice s, with one vector for the care flags and one for the values. A care bit requires the XOR of the chain's selected channel variables to equal its value bit.
- R3: Chains whose care flag is 0 have no effect. Flipping their value bits leaves every slice_ok, slice_vars and encodable unchanged.
- R4: slice_ok is 1 exactly when some channel assignment satisfies every care equation of that slice.
- R5: When slice_ok is 1, slice_vars satisfies every care equation of the slice. A channel that feeds no care chain of the slice reads 0.
- R6: Each run gives exactly N_SLICES single-cycle slice_valid strobes, with slice_idx rising 0, 1, ... in order. Slice k is visible after the k*(N_CHAN+3)+N_CHAN+2-th clock edge following the edge that accepts start.
- R7: done is a single-cycle pulse N_SLICES*(N_CHAN+3) edges after the accepted start. busy is low while done is high.
- R8: At done, encodable is 1 if every slice was solvable, and 0 if any slice was not.
- R9: A start that arrives while busy is ignored. The run in progress keeps its captured pattern and matrix, and no new run begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run; the inputs are captured on this edge |
| pat_care | input | N_SLICES*N_CHAINS | Care flag per chain per slice |
| pat_val | input | N_SLICES*N_CHAINS | Target value per chain per slice |
| chan_mat | input | N_CHAINS*N_CHAN | Channel-to-chain XOR connection matrix |
| busy | output | 1 | Run in progress |
| done | output | 1 | Pattern verdict strobe |
| encodable | output | 1 | Pattern verdict, valid with done |
| slice_valid | output | 1 | Per-slice result strobe |
| slice_idx | output | max(1,clog2(N_SLICES)) | Slice being reported |
| slice_ok | output | 1 | Slice system is solvable |
| slice_vars | output | N_CHAN | Channel assignment for the slice |

## Verification
The interesting collision is a new start that arrives in the very cycle the last slice reports its strobe. In that cycle the sequencer is still busy but is about to return to idle. The bench drives start, together with a different pattern and matrix, exactly in that cycle. It then checks three things: the verdict of the original pattern still appears on the expected edge, done fires only once, and busy stays low afterwards. A second collision is the elimination itself: row swap and reduction happen in the same cycle. Random matrices with sparse and dense care masks are judged against a brute-force search over all channel assignments.

// File: rtl/xdec_pkg.sv
package xdec_pkg;

    typedef enum logic [1:0] {
        SV_IDLE   = 2'd0,
        SV_ELIM   = 2'd1,
        SV_FINISH = 2'd2
    } solve_st_e;

    typedef enum logic {
        PT_IDLE = 1'b0,
        PT_RUN  = 1'b1
    } pat_st_e;

endpackage

// File: rtl/xdec_pivot_step.sv
// One column of GF(2) elimination: pivot search, row swap, reduction of all other rows.
module xdec_pivot_step #(
    parameter int N_ROWS = 8,
    parameter int N_COLS = 4,
    localparam int CW = (N_COLS > 1) ? $clog2(N_COLS) : 1,
    localparam int RW = $clog2(N_ROWS + 1),
    localparam int IW = (N_ROWS > 1) ? $clog2(N_ROWS) : 1
) (
    input  logic [N_ROWS-1:0][N_COLS-1:0] coef_i,
    input  logic [N_ROWS-1:0]             rhs_i,
    input  logic [CW-1:0]                 col_i,
    input  logic [RW-1:0]                 rank_i,
    output logic [N_ROWS-1:0][N_COLS-1:0] coef_o,
    output logic [N_ROWS-1:0]             rhs_o,
    output logic [RW-1:0]                 rank_o
);

    logic              found;
    logic [IW-1:0]     piv;
    logic [IW-1:0]     top;
    logic [N_COLS-1:0] pc;
    logic              pr;

    always_comb begin
        found = 1'b0;
        piv   = '0;
        for (int k = 0; k < N_ROWS; k++) begin
            if (!found && (RW'(k) >= rank_i) && coef_i[k][col_i]) begin
                found = 1'b1;
                piv   = IW'(k);
            end
        end
        top    = rank_i[IW-1:0];
        coef_o = coef_i;
        rhs_o  = rhs_i;
        if (found) begin
            coef_o[top] = coef_i[piv];
            coef_o[piv] = coef_i[top];
            rhs_o[top]  = rhs_i[piv];
            rhs_o[piv]  = rhs_i[top];
        end
        pc = coef_o[top];
        pr = rhs_o[top];
        for (int k = 0; k < N_ROWS; k++) begin
            if (found && (IW'(k) != top) && coef_o[k][col_i]) begin
                coef_o[k] = coef_o[k] ^ pc;
                rhs_o[k]  = rhs_o[k] ^ pr;
            end
        end
        rank_o = rank_i + RW'(found);
    end

endmodule

// File: rtl/xdec_slice_solver.sv
// Solves one slice: load care rows, V elimination cycles, one finish cycle.
module xdec_slice_solver
    import xdec_pkg::*;
#(
    parameter int N_CHAINS = 8,
    parameter int N_CHAN   = 4,
    localparam int CW = (N_CHAN > 1) ? $clog2(N_CHAN) : 1,
    localparam int RW = $clog2(N_CHAINS + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [N_CHAINS-1:0]        care,
    input  logic [N_CHAINS-1:0]        val,
    input  logic [N_CHAINS*N_CHAN-1:0] mat,
    output logic                       busy,
    output logic                       done,
    output logic                       ok,
    output logic [N_CHAN-1:0]          vars
);

    typedef struct packed {
        solve_st_e                          st;
        logic [N_CHAINS-1:0][N_CHAN-1:0]    coef;
        logic [N_CHAINS-1:0]                rhs;
        logic [CW-1:0]                      col;
        logic [RW-1:0]                      rank;
        logic                               done;
        logic                               ok;
        logic [N_CHAN-1:0]                  vars;
    } slv_t;

    slv_t s_q, s_d;

    logic [N_CHAINS-1:0][N_CHAN-1:0] step_coef;
    logic [N_CHAINS-1:0]             step_rhs;
    logic [RW-1:0]                   step_rank;

    xdec_pivot_step #(.N_ROWS(N_CHAINS), .N_COLS(N_CHAN)) u_step (
        .coef_i (s_q.coef),
        .rhs_i  (s_q.rhs),
        .col_i  (s_q.col),
        .rank_i (s_q.rank),
        .coef_o (step_coef),
        .rhs_o  (step_rhs),
        .rank_o (step_rank)
    );

    always_comb begin
        logic              bad;
        logic [N_CHAN-1:0] v;
        int                fb;
        s_d      = s_q;
        s_d.done = 1'b0;
        bad      = 1'b0;
        v        = '0;
        fb       = 0;
        case (s_q.st)
            SV_IDLE: begin
                if (start) begin
                    for (int i = 0; i < N_CHAINS; i++) begin
                        s_d.coef[i] = care[i] ? mat[i*N_CHAN +: N_CHAN] : '0;
                        s_d.rhs[i]  = care[i] & val[i];
                    end
                    s_d.col  = '0;
                    s_d.rank = '0;
                    s_d.st   = SV_ELIM;
                end
            end
            SV_ELIM: begin
                s_d.coef = step_coef;
                s_d.rhs  = step_rhs;
                s_d.rank = step_rank;
                if (s_q.col == CW'(N_CHAN - 1)) begin
                    s_d.st = SV_FINISH;
                end else begin
                    s_d.col = s_q.col + 1'b1;
                end
            end
            SV_FINISH: begin
                for (int k = 0; k < N_CHAINS; k++) begin
                    if (s_q.coef[k] == '0) begin
                        bad = bad | s_q.rhs[k];
                    end else begin
                        for (int j = N_CHAN - 1; j >= 0; j--) begin
                            if (s_q.coef[k][j]) fb = j;
                        end
                        v[fb] = s_q.rhs[k];
                    end
                end
                s_d.ok   = !bad;
                s_d.vars = bad ? '0 : v;
                s_d.done = 1'b1;
                s_d.st   = SV_IDLE;
            end
            default: s_d.st = SV_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy = (s_q.st != SV_IDLE);
    assign done = s_q.done;
    assign ok   = s_q.ok;
    assign vars = s_q.vars;

    function automatic logic sol_holds(input logic [N_CHAINS-1:0] c,
                                       input logic [N_CHAINS-1:0] t,
                                       input logic [N_CHAINS*N_CHAN-1:0] m,
                                       input logic [N_CHAN-1:0] x);
        logic good;
        good = 1'b1;
        for (int i = 0; i < N_CHAINS; i++) begin
            if (c[i] && ((^(m[i*N_CHAN +: N_CHAN] & x)) != t[i])) good = 1'b0;
        end
        return good;
    endfunction

    // R5: a reported assignment reproduces every care bit of the slice
    always @(posedge clk) begin
        if (rst_n && s_q.done && s_q.ok) begin
            a_r5_solution_holds: assert (sol_holds(care, val, mat, s_q.vars))
                else $error("solver assignment violates a care equation");
        end
    end

    // R6: slice strobe lasts one cycle
    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |=> !s_q.done);

    // R4: rank never exceeds the number of free variables
    a_r4_rank_bound: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.rank <= RW'(N_CHAN));

endmodule

// File: rtl/xdec_pattern_check.sv
// Captures a pattern and steps the slice solver over every slice in order.
module xdec_pattern_check
    import xdec_pkg::*;
#(
    parameter int N_CHAINS = 8,
    parameter int N_CHAN   = 4,
    parameter int N_SLICES = 4,
    localparam int SW = (N_SLICES > 1) ? $clog2(N_SLICES) : 1,
    localparam int PW = N_SLICES * N_CHAINS,
    localparam int MW = N_CHAINS * N_CHAN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [PW-1:0]     pat_care,
    input  logic [PW-1:0]     pat_val,
    input  logic [MW-1:0]     chan_mat,
    output logic              busy,
    output logic              done,
    output logic              encodable,
    output logic              slice_valid,
    output logic [SW-1:0]     slice_idx,
    output logic              slice_ok,
    output logic [N_CHAN-1:0] slice_vars
);

    typedef struct packed {
        pat_st_e       st;
        logic [PW-1:0] care;
        logic [PW-1:0] val;
        logic [MW-1:0] mat;
        logic [SW-1:0] idx;
        logic          kick;
        logic          all_ok;
        logic          done;
        logic          enc;
    } seq_t;

    seq_t p_q, p_d;

    logic              s_busy;
    logic              s_done;
    logic              s_ok;
    logic [N_CHAN-1:0] s_vars;

    xdec_slice_solver #(.N_CHAINS(N_CHAINS), .N_CHAN(N_CHAN)) u_solver (
        .clk   (clk),
        .rst_n (rst_n),
        .start (p_q.kick),
        .care  (p_q.care[p_q.idx*N_CHAINS +: N_CHAINS]),
        .val   (p_q.val[p_q.idx*N_CHAINS +: N_CHAINS]),
        .mat   (p_q.mat),
        .busy  (s_busy),
        .done  (s_done),
        .ok    (s_ok),
        .vars  (s_vars)
    );

    always_comb begin
        p_d      = p_q;
        p_d.kick = 1'b0;
        p_d.done = 1'b0;
        case (p_q.st)
            PT_IDLE: begin
                if (start) begin
                    p_d.care   = pat_care;
                    p_d.val    = pat_val;
                    p_d.mat    = chan_mat;
                    p_d.idx    = '0;
                    p_d.kick   = 1'b1;
                    p_d.all_ok = 1'b1;
                    p_d.enc    = 1'b0;
                    p_d.st     = PT_RUN;
                end
            end
            PT_RUN: begin
                if (s_done) begin
                    p_d.all_ok = p_q.all_ok & s_ok;
                    if (p_q.idx == SW'(N_SLICES - 1)) begin
                        p_d.done = 1'b1;
                        p_d.enc  = p_q.all_ok & s_ok;
                        p_d.st   = PT_IDLE;
                    end else begin
                        p_d.idx  = p_q.idx + 1'b1;
                        p_d.kick = 1'b1;
                    end
                end
            end
            default: p_d.st = PT_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign busy        = (p_q.st == PT_RUN);
    assign done        = p_q.done;
    assign encodable   = p_q.enc;
    assign slice_valid = s_done;
    assign slice_idx   = p_q.idx;
    assign slice_ok    = s_ok;
    assign slice_vars  = s_vars;

    // R9: a start seen while busy leaves the captured run untouched
    a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(p_q.care) && $stable(p_q.val) && $stable(p_q.mat)));

    // R7: the verdict strobe never overlaps a run in progress
    a_r7_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R6: slice results appear only inside a run
    a_r6_strobe_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        slice_valid |-> busy);

    // R6: the solver is never kicked while already working
    a_r6_no_double_kick: assert property (@(posedge clk) disable iff (!rst_n)
        p_q.kick |-> !s_busy);

endmodule

// File: tb/xdec_pattern_check_bench.sv
module xdec_pattern_check_bench;

    localparam int N = 8;
    localparam int V = 4;
    localparam int L = 4;
    localparam int CLK_P = 10;
    localparam int SW = (L > 1) ? $clog2(L) : 1;
    localparam int PER = V + 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [L*N-1:0]   pat_care = '0;
    logic [L*N-1:0]   pat_val = '0;
    logic [N*V-1:0]   chan_mat = '0;
    logic             busy, done, encodable, slice_valid, slice_ok;
    logic [SW-1:0]    slice_idx;
    logic [V-1:0]     slice_vars;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic           rec_ok [L];
    logic [V-1:0]   rec_vars [L];
    logic           rec_enc;

    xdec_pattern_check #(.N_CHAINS(N), .N_CHAN(V), .N_SLICES(L)) u_xdec_pattern_check (
        .clk(clk), .rst_n(rst_n), .start(start),
        .pat_care(pat_care), .pat_val(pat_val), .chan_mat(chan_mat),
        .busy(busy), .done(done), .encodable(encodable),
        .slice_valid(slice_valid), .slice_idx(slice_idx),
        .slice_ok(slice_ok), .slice_vars(slice_vars)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input bit cond, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic bit sat(input logic [N-1:0] c, input logic [N-1:0] t,
                               input logic [N*V-1:0] m, input logic [V-1:0] x);
        for (int i = 0; i < N; i++)
            if (c[i] && ((^(m[i*V +: V] & x)) != t[i])) return 0;
        return 1;
    endfunction

    function automatic bit solvable(input logic [N-1:0] c, input logic [N-1:0] t,
                                    input logic [N*V-1:0] m);
        for (int x = 0; x < (1 << V); x++)
            if (sat(c, t, m, V'(x))) return 1;
        return 0;
    endfunction

    function automatic logic [V-1:0] used_chan(input logic [N-1:0] c,
                                               input logic [N*V-1:0] m);
        logic [V-1:0] u = '0;
        for (int i = 0; i < N; i++) if (c[i]) u |= m[i*V +: V];
        return u;
    endfunction

    task automatic run(input logic [L*N-1:0] c, input logic [L*N-1:0] t,
                       input logic [N*V-1:0] m, input bit inject);
        int edges = 0;
        int got = 0;
        bit seen_done = 0;
        bit exp_enc = 1;
        for (int s = 0; s < L; s++)
            exp_enc &= solvable(c[s*N +: N], t[s*N +: N], m);
        @(negedge clk);
        pat_care = c; pat_val = t; chan_mat = m; start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        while (!seen_done && edges < 400) begin
            @(posedge clk); #1;
            edges++;
            if (inject && edges == L*PER - 1) begin
                start = 1'b1; pat_care = ~c; pat_val = ~t; chan_mat = ~m;
            end
            if (inject && edges == L*PER) start = 1'b0;
            if (slice_valid) begin
                logic [N-1:0] sc, st;
                bit eok;
                sc = c[got*N +: N]; st = t[got*N +: N];
                eok = solvable(sc, st, m);
                chk(int'(slice_idx) == got, "R6", "slice index", int'(slice_idx), got);
                chk(edges == got*PER + V + 2, "R6", "slice timing", edges, got*PER + V + 2);
                chk(slice_ok == eok, "R4", "slice_ok", int'(slice_ok), int'(eok));
                if (eok && slice_ok) begin
                    chk(sat(sc, st, m, slice_vars), "R2", "vars reproduce care bits",
                        int'(slice_vars), -1);
                    chk((slice_vars & ~used_chan(sc, m)) == '0, "R5", "unused channels zero",
                        int'(slice_vars), int'(slice_vars & used_chan(sc, m)));
                end
                if (got < L) begin
                    rec_ok[got] = slice_ok; rec_vars[got] = slice_vars;
                end
                got++;
            end
            if (done) begin
                seen_done = 1;
                chk(edges == L*PER, "R7", "done timing", edges, L*PER);
                chk(!busy, "R7", "busy low at done", int'(busy), 0);
                chk(got == L, "R6", "strobe count", got, L);
                chk(encodable == exp_enc, "R8", "encodable", int'(encodable), int'(exp_enc));
                rec_enc = encodable;
            end
        end
        chk(seen_done, "R7", "done seen", int'(seen_done), 1);
        @(posedge clk); #1;
        chk(!done, "R7", "done single cycle", int'(done), 0);
        if (inject) begin
            repeat (3) begin
                @(posedge clk); #1;
                chk(!busy && !slice_valid, "R9", "no run from start while busy",
                    int'(busy), 0);
            end
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [N*V-1:0] m;
        logic [L*N-1:0] c, t;
        logic           save_ok [L];
        logic [V-1:0]   save_vars [L];
        logic           save_enc;
        void'($urandom(32'h5EED_1234));
        repeat (3) @(posedge clk);
        #1;
        chk(!busy && !done && !slice_valid, "R1", "reset outputs low",
            int'({busy, done, slice_valid}), 0);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);

        // R3 R5: no care bits at all
        m = $urandom;
        run('0, $urandom, m, 0);
        for (int s = 0; s < L; s++)
            chk(rec_vars[s] == '0, "R5", "all-free slice vars zero", int'(rec_vars[s]), 0);

        // R2: chain i fed only by channel i%V
        for (int i = 0; i < N; i++) m[i*V +: V] = V'(1 << (i % V));
        t = $urandom;
        for (int s = 0; s < L; s++)
            for (int i = V; i < N; i++) t[s*N + i] = t[s*N + i - V];
        run('1, t, m, 0);
        chk(rec_vars[1] == t[N +: V], "R2", "direct channel values",
            int'(rec_vars[1]), int'(t[N +: V]));

        // R4 R8: contradiction in slice 2 only
        m = $urandom; m[0 +: V] = 4'b0110; m[V +: V] = 4'b0110;
        c = '0; t = '0;
        c[2*N +: 2] = 2'b11; t[2*N +: 2] = 2'b01;
        run(c, t, m, 0);
        chk(rec_ok[2] == 1'b0, "R4", "contradicting slice", int'(rec_ok[2]), 0);
        chk(rec_enc == 1'b0, "R8", "one bad slice fails pattern", int'(rec_enc), 0);

        // R3: flipping don't-care values changes nothing
        repeat (6) begin
            m = $urandom; c = $urandom & $urandom; t = $urandom;
            run(c, t, m, 0);
            for (int s = 0; s < L; s++) begin
                save_ok[s] = rec_ok[s]; save_vars[s] = rec_vars[s];
            end
            save_enc = rec_enc;
            run(c, t ^ ~c, m, 0);
            for (int s = 0; s < L; s++) begin
                chk(rec_ok[s] == save_ok[s], "R3", "dont-care ok unchanged",
                    int'(rec_ok[s]), int'(save_ok[s]));
                chk(rec_vars[s] == save_vars[s], "R3", "dont-care vars unchanged",
                    int'(rec_vars[s]), int'(save_vars[s]));
            end
            chk(rec_enc == save_enc, "R3", "dont-care verdict unchanged",
                int'(rec_enc), int'(save_enc));
        end

        // R9: start with new data in the cycle of the last slice strobe
        m = $urandom; c = $urandom & $urandom & $urandom; t = $urandom;
        run(c, t, m, 1);

        // random runs with varied care density
        for (int r = 0; r < 40; r++) begin
            m = $urandom;
            case (r % 3)
                0: c = $urandom & $urandom & $urandom;
                1: c = $urandom & $urandom;
                default: c = $urandom;
            endcase
            t = $urandom;
            run(c, t, m, 0);
        end

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule